// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-lane SPI master run by software through a small word-addressed register space. Software places up to nine bytes in a byte buffer and then writes a transfer word. That word names one of four select lines, a total byte count, the number of those bytes that carry real transmit data, and a flag that keeps the select line asserted after the transfer. The block then runs the frame with a serial clock derived from its input clock. Each received byte overwrites the buffer entry of the same index, so software reads the results from the same place it wrote the outgoing data.

A configuration word sets the following: block enable, serial-clock rest level, a late-select option that adds half a serial period of setup after the select line asserts, LSB-first bit order, select-line polarity, per-line select enables and a 13-bit half-period divider. A status word reports busy. A run of transfers with the hold flag set forms one long frame on a single select line.

Top module: `spi_regmaster`

## Requirements
- R1: After reset every register reads zero, status busy (bit 0 at 0x008) is 0, sclk rests high, mosi is 1 and every select line reads 1.
- R2: The configuration word at 0x000 holds the following fields: enable in bit 0, clock rest-low in bit 1, LSB-first in bit 4, active-high selects in bit 7, late select in bit 11, select enables in bits 15:12 and the divider in bits 28:16. All other bits read back as 0.
- R3: Buffer entry i (0 to 8) sits at 0x080 + 8*i. Only bits 7:0 are stored; the other bits read 0. Addresses past the ninth entry read 0.
- R4: Writing the transfer word at 0x010 (total count in bits 4:0, transmit count in bits 12:8, hold flag in bit 16, select index in bits 21:20) starts a transfer when the block is enabled and idle. The total is clamped to 9, the transmit count is clamped to the total, and the clamped fields read back at 0x010.
- R5: Busy is 1 from the cycle after the transfer word is accepted through (late + 16*total + 1) half periods, and 0 after that.
- R6: A half period of sclk lasts max(divider,1) input clocks.
- R7: With rest-low set, sclk rests low, input is sampled on the rising edge and output changes on the falling edge. With rest-low clear, sclk rests high and the roles of the edges are swapped. Each bit takes one idle-level half period followed by one active-level half period, and a final idle half period closes the frame.
- R8: With late select set, one extra idle half period with mosi at 1 comes before the first bit.
- R9: Bits go out and come in MSB first unless LSB-first is set.
- R10: Bytes below the transmit count are shifted out from buffer entries 0 upward. While the remaining bytes shift, mosi stays at 1. Every byte received overwrites the buffer entry of its index, and entries at or above the total count are left unchanged.
- R11: Only the indexed select line is driven active during a transfer, and only if its enable bit is set. The active level is 1 with active-high set and 0 otherwise. After the transfer the line stays active if the hold flag was set and returns inactive if not. Clearing enable releases a held line.
- R12: Writes to the transfer, configuration or buffer registers while busy are ignored. A transfer word written while the block is disabled, or with a total of 0, starts nothing: busy stays 0, no select line asserts and the stored transfer fields do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | 4 | Select lines, level set by polarity |

## Verification
The assertions check the following on every cycle: no more than one select line is active, sclk sits at its rest level whenever the block is idle, busy rises only after an enabled transfer write, and the configuration and latched transfer fields hold steady while busy. They also check that a select line is released when the hold flag was clear and that sclk never toggles on back-to-back clocks when the divider is 2 or more. Only the bench scenarios show the exact edge timing, which depends on the divider, late select, rest level and bit order. The same holds for the split between data and fill bytes, received bytes landing at the right buffer index, held-frame continuation, and disturbing writes having no effect.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;
  localparam int NUM_CS    = 4;
  localparam int CS_W      = $clog2(NUM_CS);
  localparam int BUF_DEPTH = 9;
  localparam int IDX_W     = $clog2(BUF_DEPTH);
  localparam int CNT_W     = 5;
  localparam int DIV_W     = 13;
  localparam int HALF_W    = $clog2(16 * BUF_DEPTH + 2);
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 12'h000;
  localparam logic [ADDR_W-1:0] ADDR_STS  = 12'h008;
  localparam logic [ADDR_W-1:0] ADDR_XFER = 12'h010;
  localparam logic [ADDR_W-1:0] BUF_BASE  = 12'h080;
  localparam logic [ADDR_W-1:0] BUF_END   = BUF_BASE + ADDR_W'(8 * BUF_DEPTH);

  localparam int B_EN      = 0;
  localparam int B_IDLELOW = 1;
  localparam int B_LSB     = 4;
  localparam int B_CSHIGH  = 7;
  localparam int B_LATE    = 11;
  localparam int CSEN_LSB  = 12;
  localparam int DIV_LSB   = 16;

  localparam int TOT_LSB   = 0;
  localparam int TX_LSB    = 8;
  localparam int B_HOLD    = 16;
  localparam int CSID_LSB  = 20;

  typedef struct packed {
    logic              enable;
    logic              idleLow;
    logic              lsbFirst;
    logic              csHigh;
    logic              lateSel;
    logic [NUM_CS-1:0] csEn;
    logic [DIV_W-1:0]  div;
  } cfg_t;

  typedef struct packed {
    logic             accept;
    logic             captureBit;
    logic             storeByte;
    logic             dataRegion;
    logic [IDX_W-1:0] byteIdx;
    logic [2:0]       bitIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/spi_regmaster_dp.sv
module spi_regmaster_dp
  import spi_regmaster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              miso,
  output logic              mosi,
  input  logic              busy,
  input  ctlStrobes_t       strb,
  output cfg_t              cfg,
  output logic              xferWrite,
  output logic [CNT_W-1:0]  reqTotal,
  output logic [CNT_W-1:0]  totalCnt,
  output logic              holdSel,
  output logic [CS_W-1:0]   csIdx
);
  logic [7:0]        bufMem [BUF_DEPTH];
  logic [7:0]        rxByte;
  logic [CNT_W-1:0]  txCnt;
  logic [CNT_W-1:0]  fieldTot, fieldTx, reqTx;
  logic              wrCfg, bufHit;
  logic [ADDR_W-1:0] bufOff;
  logic [IDX_W-1:0]  bufIdx, safeIdx;
  logic [2:0]        bitSel;
  logic [7:0]        curByte;
  logic              unusedBits;

  assign unusedBits = ^{regWrData[31:29], regWrData[6:5], regWrData[3:2]};

  assign wrCfg     = regWrEn && (regAddr == ADDR_CFG);
  assign xferWrite = regWrEn && (regAddr == ADDR_XFER);
  assign bufHit    = (regAddr >= BUF_BASE) && (regAddr < BUF_END) && (regAddr[2:0] == 3'b000);
  assign bufOff    = regAddr - BUF_BASE;
  assign bufIdx    = bufOff[3 +: IDX_W];

  assign fieldTot = regWrData[TOT_LSB +: CNT_W];
  assign fieldTx  = regWrData[TX_LSB +: CNT_W];
  assign reqTotal = (fieldTot > CNT_W'(BUF_DEPTH)) ? CNT_W'(BUF_DEPTH) : fieldTot;
  assign reqTx    = (fieldTx > reqTotal) ? reqTotal : fieldTx;

  // Transmit bit selection straight from the buffer; the entry is only
  // overwritten by its own received byte after its last bit has gone out.
  assign bitSel  = cfg.lsbFirst ? strb.bitIdx : (3'd7 - strb.bitIdx);
  assign safeIdx = (strb.byteIdx < IDX_W'(BUF_DEPTH)) ? strb.byteIdx : '0;
  assign curByte = bufMem[safeIdx];
  assign mosi    = (strb.dataRegion && (CNT_W'(strb.byteIdx) < txCnt)) ? curByte[bitSel] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      totalCnt <= '0;
      txCnt    <= '0;
      holdSel  <= 1'b0;
      csIdx    <= '0;
      rxByte   <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
    end else begin
      if (wrCfg && !busy) begin
        cfg.enable   <= regWrData[B_EN];
        cfg.idleLow  <= regWrData[B_IDLELOW];
        cfg.lsbFirst <= regWrData[B_LSB];
        cfg.csHigh   <= regWrData[B_CSHIGH];
        cfg.lateSel  <= regWrData[B_LATE];
        cfg.csEn     <= regWrData[CSEN_LSB +: NUM_CS];
        cfg.div      <= regWrData[DIV_LSB +: DIV_W];
      end
      if (strb.accept) begin
        totalCnt <= reqTotal;
        txCnt    <= reqTx;
        holdSel  <= regWrData[B_HOLD];
        csIdx    <= regWrData[CSID_LSB +: CS_W];
      end
      if (regWrEn && bufHit && !busy) bufMem[bufIdx] <= regWrData[7:0];
      if (strb.captureBit) rxByte[bitSel] <= miso;
      if (strb.storeByte) bufMem[safeIdx] <= rxByte;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CFG) begin
      regRdData[B_EN]                = cfg.enable;
      regRdData[B_IDLELOW]           = cfg.idleLow;
      regRdData[B_LSB]               = cfg.lsbFirst;
      regRdData[B_CSHIGH]            = cfg.csHigh;
      regRdData[B_LATE]              = cfg.lateSel;
      regRdData[CSEN_LSB +: NUM_CS]  = cfg.csEn;
      regRdData[DIV_LSB +: DIV_W]    = cfg.div;
    end else if (regAddr == ADDR_STS) begin
      regRdData[0] = busy;
    end else if (regAddr == ADDR_XFER) begin
      regRdData[TOT_LSB +: CNT_W]  = totalCnt;
      regRdData[TX_LSB +: CNT_W]   = txCnt;
      regRdData[B_HOLD]            = holdSel;
      regRdData[CSID_LSB +: CS_W]  = csIdx;
    end else if (bufHit) begin
      regRdData[7:0] = bufMem[bufIdx];
    end
  end
endmodule

// File: rtl/spi_regmaster_ctl.sv
module spi_regmaster_ctl
  import spi_regmaster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  logic              xferWrite,
  input  logic [CNT_W-1:0]  reqTotal,
  input  logic [CNT_W-1:0]  totalCnt,
  input  logic              holdSel,
  input  logic [CS_W-1:0]   csIdx,
  output ctlStrobes_t       strb,
  output logic              busy,
  output logic              sclk,
  output logic [NUM_CS-1:0] csOut
);
  logic [DIV_W-1:0]  halfCnt, divEff;
  logic [HALF_W-1:0] halfIdx, lastHalf, lateOff, hPrime, dataHalves;
  logic              csActive, advance, accept, inData, activeHalf;
  logic              unusedCfg;

  assign unusedCfg = cfg.lsbFirst;

  assign divEff     = (cfg.div == '0) ? DIV_W'(1) : cfg.div;
  assign lateOff    = HALF_W'(cfg.lateSel);
  assign dataHalves = HALF_W'({totalCnt, 4'b0000});
  assign lastHalf   = lateOff + dataHalves;
  assign hPrime     = halfIdx - lateOff;

  assign inData     = busy && (halfIdx >= lateOff) && (hPrime < dataHalves);
  assign activeHalf = inData && hPrime[0];
  assign advance    = busy && (halfCnt == divEff - DIV_W'(1));
  assign accept     = xferWrite && !busy && cfg.enable && (reqTotal != '0);

  assign strb.accept     = accept;
  assign strb.captureBit = advance && inData && !hPrime[0];
  assign strb.storeByte  = advance && activeHalf && (hPrime[3:1] == 3'd7);
  assign strb.dataRegion = inData;
  assign strb.byteIdx    = hPrime[4 +: IDX_W];
  assign strb.bitIdx     = hPrime[3:1];

  assign sclk = cfg.idleLow ? activeHalf : ~activeHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      halfCnt  <= '0;
      halfIdx  <= '0;
      csActive <= 1'b0;
    end else begin
      if (accept) begin
        busy     <= 1'b1;
        halfCnt  <= '0;
        halfIdx  <= '0;
        csActive <= 1'b1;
      end else if (busy) begin
        if (advance) begin
          halfCnt <= '0;
          if (halfIdx == lastHalf) begin
            busy     <= 1'b0;
            csActive <= holdSel;
          end else begin
            halfIdx <= halfIdx + HALF_W'(1);
          end
        end else begin
          halfCnt <= halfCnt + DIV_W'(1);
        end
      end
      if (!cfg.enable) csActive <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csOut[i] = (csActive && (csIdx == CS_W'(i)) && cfg.csEn[i]) ? cfg.csHigh : ~cfg.csHigh;
  end
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_regmaster_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csOut
);
  cfg_t             cfg;
  ctlStrobes_t      strb;
  logic             busy, xferWrite, holdSel;
  logic [CNT_W-1:0] reqTotal, totalCnt;
  logic [CS_W-1:0]  csIdx;

  spi_regmaster_dp u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .miso(miso), .mosi(mosi),
    .busy(busy), .strb(strb), .cfg(cfg), .xferWrite(xferWrite),
    .reqTotal(reqTotal), .totalCnt(totalCnt), .holdSel(holdSel), .csIdx(csIdx)
  );

  spi_regmaster_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .xferWrite(xferWrite),
    .reqTotal(reqTotal), .totalCnt(totalCnt), .holdSel(holdSel), .csIdx(csIdx),
    .strb(strb), .busy(busy), .sclk(sclk), .csOut(csOut)
  );
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk
  import spi_regmaster_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              sclk,
  input logic [NUM_CS-1:0] csOut,
  input cfg_t              cfg,
  input logic              xferWrite,
  input logic              holdSel,
  input logic [CNT_W-1:0]  totalCnt,
  input logic [CS_W-1:0]   csIdx
);
  logic [NUM_CS-1:0] activeVec;
  assign activeVec = csOut ^ {NUM_CS{~cfg.csHigh}};

  p_single_select_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(activeVec));

  p_rest_clock_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == ~cfg.idleLow));

  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(xferWrite && cfg.enable));

  p_xfer_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferWrite) |=> ($stable(totalCnt) && $stable(csIdx) && $stable(holdSel)));

  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfg));

  p_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !holdSel) |-> (activeVec == '0));

  p_half_period_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclk) && (cfg.div >= DIV_W'(2))) |=> $stable(sclk));
endmodule

bind spi_regmaster spi_regmaster_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclk(sclk), .csOut(csOut), .cfg(cfg),
  .xferWrite(xferWrite), .holdSel(holdSel), .totalCnt(totalCnt), .csIdx(csIdx)
);

// File: tb/spi_regmaster_bench.sv
module spi_regmaster_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        sclk, mosi, miso;
  logic [3:0]  csOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bit       mEnable, mIdleLow, mLsb, mCsHigh, mLate;
  bit [3:0] mCsEn;
  int       mDiv;
  logic [7:0] bufModel [9];
  int heldCs = -1;
  logic [31:0] cfgWord;

  always #10 clk = ~clk;

  spi_regmaster u_spi_regmaster (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csOut(csOut)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expCs(input int sel);
    logic [3:0] v;
    for (int i = 0; i < 4; i++)
      v[i] = (i == sel && mCsEn[i]) ? mCsHigh : !mCsHigh;
    return v;
  endfunction

  function automatic logic [31:0] xferWord(input int tot, input int tx, input int sel, input bit hold);
    return (32'(sel & 3) << 20) | (32'(hold) << 16) | (32'(tx & 31) << 8) | 32'(tot & 31);
  endfunction

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 12'h008;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic cfgWrite(input bit en, input bit il, input bit lsb, input bit ch,
                          input bit late, input bit [3:0] ce, input int div);
    mEnable = en; mIdleLow = il; mLsb = lsb; mCsHigh = ch; mLate = late; mCsEn = ce; mDiv = div;
    cfgWord = 32'(en) | (32'(il) << 1) | (32'(lsb) << 4) | (32'(ch) << 7) |
              (32'(late) << 11) | (32'(ce) << 12) | (32'(div & 13'h1fff) << 16);
    if (!en) heldCs = -1;
    regWrite(12'h000, cfgWord | 32'h4000_0008);
  endtask

  task automatic checkIdle(input string req);
    @(negedge clk);
    regAddr = 12'h008;
    #1;
    check(req, "busy idle", {31'b0, regRdData[0]}, 0);
    check(req, "sclk idle", {31'b0, sclk}, {31'b0, !mIdleLow});
    check(req, "mosi idle", {31'b0, mosi}, 1);
    check(req, "cs idle", {28'b0, csOut}, {28'b0, expCs(heldCs)});
  endtask

  task automatic checkBuffer(input string req);
    logic [31:0] d;
    for (int b = 0; b < 9; b++) begin
      regRead(12'h080 + 12'(8 * b), d);
      check(req, $sformatf("buffer entry %0d", b), d, {24'b0, bufModel[b]});
    end
  endtask

  task automatic runXfer(input int totF, input int txF, input int sel, input bit hold,
                         input bit disturb, input int seed);
    int tt, tc, dd, ll, nn;
    logic [7:0] slv [9];
    tt = (totF > 9) ? 9 : totF;
    tc = (txF > tt) ? tt : txF;
    dd = (mDiv == 0) ? 1 : mDiv;
    ll = mLate;
    nn = ll + 16 * tt + 1;
    for (int b = 0; b < 9; b++) slv[b] = 8'((seed * 13 + b * 59 + 7) ^ (b << 4));
    @(negedge clk);
    regAddr = 12'h010; regWrData = xferWord(totF, txF, sel, hold); regWrEn = 1'b1;
    for (int k = 0; k < nn * dd; k++) begin
      int h, hp, bi, bt, bs;
      bit inData, act;
      logic expSclk, expMosi;
      @(negedge clk);
      regWrEn = 1'b0; regAddr = 12'h008;
      if (disturb && k == 5) begin regAddr = 12'h010; regWrData = xferWord(1, 1, 0, 0); regWrEn = 1'b1; end
      if (disturb && k == 6) begin regAddr = 12'h080; regWrData = 32'h0000_0033; regWrEn = 1'b1; end
      if (disturb && k == 7) begin regAddr = 12'h000; regWrData = 32'h0; regWrEn = 1'b1; end
      #1;
      h = k / dd;
      hp = h - ll;
      inData = (h >= ll) && (hp < 16 * tt);
      bi = inData ? hp / 16 : 0;
      bt = inData ? (hp / 2) % 8 : 0;
      bs = mLsb ? bt : 7 - bt;
      act = inData && (hp % 2 == 1);
      expSclk = act ? mIdleLow : !mIdleLow;
      expMosi = (inData && bi < tc) ? bufModel[bi][bs] : 1'b1;
      check("R6,R7,R8", $sformatf("sclk cycle %0d", k), {31'b0, sclk}, {31'b0, expSclk});
      check("R9,R10", $sformatf("mosi cycle %0d", k), {31'b0, mosi}, {31'b0, expMosi});
      check("R11", $sformatf("cs cycle %0d", k), {28'b0, csOut}, {28'b0, expCs(sel)});
      if (!(disturb && k >= 5 && k <= 7))
        check("R5", $sformatf("busy cycle %0d", k), {31'b0, regRdData[0]}, 1);
      miso = inData ? slv[bi][bs] : 1'b0;
    end
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 12'h008;
    #1;
    check("R5", "busy after end", {31'b0, regRdData[0]}, 0);
    for (int b = 0; b < tt; b++) bufModel[b] = slv[b];
    heldCs = hold ? sel : -1;
    check("R11", "cs after end", {28'b0, csOut}, {28'b0, expCs(heldCs)});
    checkBuffer("R10");
  endtask

  initial begin
    logic [31:0] d;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 12'h008; regWrData = '0; miso = 1'b0;
    mEnable = 0; mIdleLow = 0; mLsb = 0; mCsHigh = 0; mLate = 0; mCsEn = 0; mDiv = 0;
    for (int b = 0; b < 9; b++) bufModel[b] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    checkIdle("R1");
    regRead(12'h000, d); check("R1", "cfg after reset", d, 0);
    regRead(12'h010, d); check("R1", "xfer after reset", d, 0);
    regRead(12'h0A0, d); check("R1", "buffer after reset", d, 0);

    // R2 configuration fields and masking
    cfgWrite(1, 1, 0, 0, 0, 4'hF, 2);
    regRead(12'h000, d); check("R2", "cfg readback", d, cfgWord);

    // R3 buffer storage
    for (int b = 0; b < 9; b++) begin
      bufModel[b] = 8'(8'hA0 + b * 7);
      regWrite(12'h080 + 12'(8 * b), 32'h0012_0000 | 32'(bufModel[b]) | 32'h100);
    end
    checkBuffer("R3");
    regRead(12'h0C8, d); check("R3", "past last entry", d, 0);

    // Transfer A: msb first, rest low, partial transmit
    runXfer(3, 2, 1, 0, 0, 17);
    regRead(12'h010, d); check("R4", "xfer readback A", d, xferWord(3, 2, 1, 0));

    // Transfer B: rest high, lsb first, late, active-high, div 1, all fill, hold
    cfgWrite(1, 0, 1, 1, 1, 4'hF, 1);
    runXfer(2, 0, 2, 1, 0, 5);
    checkIdle("R11");

    // Transfer C: continues held frame, tx clamped to total
    runXfer(2, 7, 2, 0, 0, 9);
    regRead(12'h010, d); check("R4", "tx clamp readback", d, xferWord(2, 2, 2, 0));
    checkIdle("R11");

    // Transfer D: disabled select line, clamped counts, disturbing writes
    cfgWrite(1, 1, 0, 0, 1, 4'b1011, 3);
    runXfer(31, 15, 2, 0, 1, 3);
    regRead(12'h010, d); check("R4", "clamp and ignore readback", d, xferWord(9, 9, 2, 0));
    regRead(12'h000, d); check("R12", "cfg ignored while busy", d, cfgWord);

    // Held line released by disable, then write while disabled
    cfgWrite(1, 1, 0, 0, 0, 4'hF, 2);
    runXfer(1, 1, 3, 1, 0, 21);
    checkIdle("R11");
    cfgWrite(0, 1, 0, 0, 0, 4'hF, 2);
    checkIdle("R11");
    regWrite(12'h010, xferWord(3, 3, 0, 0));
    repeat (6) checkIdle("R12");
    regRead(12'h010, d); check("R12", "disabled write not latched", d, xferWord(1, 1, 3, 1));

    // Total zero
    cfgWrite(1, 1, 0, 0, 0, 4'hF, 2);
    regWrite(12'h010, xferWord(0, 0, 1, 1));
    repeat (6) checkIdle("R12");
    regRead(12'h010, d); check("R12", "zero total not latched", d, xferWord(1, 1, 3, 1));

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule